// File: doc/BRIEF.md
# One-shot and periodic tick timer pair

This block holds two tick timers behind a small memory-mapped register window. Timer 0 is a one-shot: once armed it counts down and fires a single expiry pulse, then disarms itself. Timer 1 is a periodic interval timer: it fires every N ticks until software stops it. A tick-enable input decides on which clock cycles the counts advance, so the same block can run from a slow time base without a separate clock.

Each timer has a control register and a remaining-ticks register. Writing a count N to the control register cancels whatever was pending and starts a fresh count of N ticks from the write. Writing zero stops and clears the timer. Reading the control register returns the last value written, which the one-shot clears to zero when it fires. Reading the remaining register returns the ticks left before expiry, or zero when the timer is idle. Only full 32-bit accesses are accepted; any other size raises an error flag and leaves the state untouched.

Top module: `tick_timer_pair`

## Requirements
- R1: After reset both control registers and both remaining registers read 0, and both expiry outputs are low.
- R2: A 4-byte write of nonzero N to a control register (one-shot at byte offset 32, periodic at offset 40) makes that control register read N and its remaining register (offset 36 for the one-shot, 44 for the periodic) read N before any tick.
- R3: A remaining count decreases by one only on clock cycles where tick_en is 1; with tick_en at 0 it holds.
- R4: An armed one-shot drives os_fire high for exactly one cycle, visible after the N-th enabled tick following the write, after which its control and remaining registers read 0 and it fires no more.
- R5: An armed periodic timer drives pd_fire high for one cycle every N enabled ticks, keeps N in its control register and reloads its remaining count to N at each expiry.
- R6: Writing 0 to a control register stops that timer: no further pulses, and both of its registers read 0.
- R7: Writing a control register while a count is pending cancels the pending expiry and restarts the count of N ticks from the write.
- R8: A control write that lands in the same cycle as an expiry takes priority: no pulse is produced and the new count starts from the write.
- R9: An access whose size field is not 4 (size counts bytes) raises err for one cycle after the request, changes no state, and a read of that kind returns 0.
- R10: Writes to the remaining registers and to unmapped offsets have no effect; reads of unmapped offsets return 0.
- R11: Every read request produces rvalid with rdata exactly one cycle later; rdata carries the register as a 32-bit big-endian word, bits 31:24 holding the byte at the register's lowest address.
- R12: The two timers count and fire independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-advance enable, one tick per high cycle |
| req | input | 1 | Bus access request, one cycle per access |
| we | input | 1 | 1 for write, 0 for read |
| addr | input | 6 | Byte offset within the block |
| size | input | 3 | Access size in bytes; only 4 is legal |
| wdata | input | 32 | Write data, big-endian word |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data strobe, one cycle after a read request |
| err | output | 1 | Bad access size, one cycle after the request |
| os_fire | output | 1 | One-shot expiry pulse |
| pd_fire | output | 1 | Periodic expiry pulse |

## Verification
The hardest situation to reach is a control write that coincides exactly with the cycle in which the remaining count would reach zero, since it needs the write edge to align with the last enabled tick. The bench arms the one-shot with a short count while tick_en is held high, counts clock edges from the write, and issues the second write on the edge where the count is one, then follows the new count edge by edge to confirm that the first pulse never appears and the second lands on time. Exact tick windows for the hold-and-advance checks are produced by raising tick_en for a counted number of edges.

// File: rtl/tt_pkg.sv
package tt_pkg;
  // Number of timers in the block; index 0 is the one-shot, 1 the periodic.
  localparam int unsigned NUM_TIMERS = 2;
  // Legal access size in bytes.
  localparam logic [2:0] FULL_WORD = 3'd4;

  typedef struct packed {
    logic wr_ok;   // legal write
    logic rd_ok;   // legal read
    logic bad;     // size error
  } acc_kind_t;
endpackage

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int unsigned W        = 32,
  parameter bit          PERIODIC = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] ctrl_o,
  output logic [W-1:0] rem_o,
  output logic         fire_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] ctrl_q, rem_q;
  logic         fire_q;
  logic         last_tick;

  assign last_tick = tick_en && (rem_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      rem_q  <= '0;
      fire_q <= 1'b0;
    end else if (load) begin
      // a write cancels the pending count and beats a coincident expiry
      ctrl_q <= load_val;
      rem_q  <= load_val;
      fire_q <= 1'b0;
    end else begin
      fire_q <= last_tick;
      if (tick_en && rem_q != '0) begin
        if (rem_q == ONE) begin
          if (PERIODIC) begin
            rem_q <= ctrl_q;
          end else begin
            rem_q  <= '0;
            ctrl_q <= '0;
          end
        end else begin
          rem_q <= rem_q - ONE;
        end
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign rem_o  = rem_q;
  assign fire_o = fire_q;
endmodule

// File: rtl/tt_regif.sv
module tt_regif
  import tt_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BASE   = 32,
  parameter int unsigned STRIDE = 8,
  parameter int unsigned NT     = NUM_TIMERS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [W-1:0]      ctrl_i [NT],
  input  logic [W-1:0]      rem_i  [NT],
  output logic [NT-1:0]     load_o,
  output logic [W-1:0]      rdata,
  output logic              rvalid,
  output logic              err
);
  acc_kind_t    kind;
  logic [W-1:0] rd_mux;

  always_comb begin
    kind.bad   = req && (size != FULL_WORD);
    kind.wr_ok = req && we  && !kind.bad;
    kind.rd_ok = req && !we && !kind.bad;
  end

  always_comb begin
    rd_mux = '0;
    load_o = '0;
    for (int i = 0; i < int'(NT); i++) begin
      if (addr == ADDR_W'(BASE + STRIDE * i)) begin
        rd_mux    = ctrl_i[i];
        load_o[i] = kind.wr_ok;
      end
      if (addr == ADDR_W'(BASE + STRIDE * i + 4)) begin
        rd_mux = rem_i[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      rvalid <= req && !we;
      err    <= kind.bad;
      rdata  <= kind.rd_ok ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
  import tt_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BASE   = 32,
  parameter int unsigned STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              rvalid,
  output logic              err,
  output logic              os_fire,
  output logic              pd_fire
);
  localparam int unsigned NT = NUM_TIMERS;

  logic [W-1:0]  ctrl_w [NT];
  logic [W-1:0]  rem_w  [NT];
  logic [NT-1:0] load_w;
  logic [NT-1:0] fire_w;

  tt_regif #(
    .W(W), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE), .NT(NT)
  ) u_regif (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .size(size),
    .ctrl_i(ctrl_w), .rem_i(rem_w), .load_o(load_w),
    .rdata(rdata), .rvalid(rvalid), .err(err)
  );

  for (genvar g = 0; g < int'(NT); g++) begin : g_tmr
    tt_counter #(.W(W), .PERIODIC(g != 0)) u_cnt (
      .clk(clk), .rst(rst), .tick_en(tick_en),
      .load(load_w[g]), .load_val(wdata),
      .ctrl_o(ctrl_w[g]), .rem_o(rem_w[g]), .fire_o(fire_w[g])
    );
  end

  // named views for the checker
  logic [W-1:0] os_ctrl_v, os_rem_v, pd_ctrl_v, pd_rem_v;
  assign os_ctrl_v = ctrl_w[0];
  assign os_rem_v  = rem_w[0];
  assign pd_ctrl_v = ctrl_w[1];
  assign pd_rem_v  = rem_w[1];

  assign os_fire = fire_w[0];
  assign pd_fire = fire_w[1];
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BASE   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [2:0]        size,
  input logic              rvalid,
  input logic              err,
  input logic              os_fire,
  input logic              pd_fire,
  input logic [W-1:0]      os_ctrl,
  input logic [W-1:0]      os_rem,
  input logic [W-1:0]      pd_ctrl,
  input logic [W-1:0]      pd_rem
);
  a_r11_rd_strobe: assert property (@(posedge clk) disable iff (rst)
    (req && !we) |=> rvalid);
  a_r11_rd_cause: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(req && !we));
  a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(req && size != 3'd4));
  a_r9_no_effect: assert property (@(posedge clk) disable iff (rst)
    (req && we && size != 3'd4 && !tick_en) |=> ($stable(os_ctrl) && $stable(pd_ctrl)));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !(req && we)) |=> ($stable(os_rem) && $stable(pd_rem)));
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    os_fire |=> !os_fire);
  a_r4_clears: assert property (@(posedge clk) disable iff (rst)
    os_fire |-> (os_ctrl == '0 && os_rem == '0));
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    pd_fire |-> (pd_rem == pd_ctrl && pd_ctrl != '0));
  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    (req && we && size == 3'd4 && addr == ADDR_W'(BASE)) |=> !os_fire);
endmodule

bind tick_timer_pair tt_checker #(.W(W), .ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .req(req), .we(we), .addr(addr),
  .size(size), .rvalid(rvalid), .err(err), .os_fire(os_fire), .pd_fire(pd_fire),
  .os_ctrl(os_ctrl_v), .os_rem(os_rem_v), .pd_ctrl(pd_ctrl_v), .pd_rem(pd_rem_v)
);

// File: tb/tick_timer_pair_tb.sv
`timescale 1ns/1ps
module tick_timer_pair_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [2:0]  size = 3'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, err, os_fire, pd_fire;

  int n_checks = 0, n_errors = 0;
  int os_cnt = 0, pd_cnt = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  tick_timer_pair u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .req(req), .we(we), .addr(addr),
    .size(size), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .err(err),
    .os_fire(os_fire), .pd_fire(pd_fire)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue and counts pulses
  always @(negedge clk) begin
    if (!rst) begin
      if (os_fire) os_cnt++;
      if (pd_fire) pd_cnt++;
      if (rvalid) begin
        if (exp_q.size() == 0) chk(1'b0, "R11 unexpected rvalid", rdata, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rdata === e, t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [2:0] s,
                    input bit exp_err, input string tag);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; size = s;
    @(negedge clk);
    req = 1'b0; we = 1'b0; size = 3'd4;
    chk(err === exp_err, {tag, " err"}, {31'h0, err}, {31'h0, exp_err});
  endtask

  task automatic rd(input logic [5:0] a, input logic [2:0] s, input logic [31:0] e,
                    input bit exp_err, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = a; size = s;
    @(negedge clk);
    req = 1'b0; size = 3'd4;
    chk(err === exp_err, {tag, " err"}, {31'h0, err}, {31'h0, exp_err});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(os_fire == 1'b0 && pd_fire == 1'b0, "R1 fire outputs", {30'h0, os_fire, pd_fire}, 32'h0);
    rd(6'd32, 3'd4, 32'd0, 1'b0, "R1 os ctrl");
    rd(6'd36, 3'd4, 32'd0, 1'b0, "R1 os rem");
    rd(6'd40, 3'd4, 32'd0, 1'b0, "R1 pd ctrl");
    rd(6'd44, 3'd4, 32'd0, 1'b0, "R1 pd rem");

    // R11 full word readback
    wr(6'd40, 32'h0A0B0C0D, 3'd4, 1'b0, "R11 write");
    rd(6'd40, 3'd4, 32'h0A0B0C0D, 1'b0, "R11 big-endian word");
    wr(6'd40, 32'd0, 3'd4, 1'b0, "R6 clear");

    // R2 / R12 arm both with ticks off
    wr(6'd32, 32'd7, 3'd4, 1'b0, "R2 os write");
    wr(6'd40, 32'd9, 3'd4, 1'b0, "R12 pd write");
    rd(6'd32, 3'd4, 32'd7, 1'b0, "R2 os ctrl");
    rd(6'd36, 3'd4, 32'd7, 1'b0, "R2 os rem");
    rd(6'd44, 3'd4, 32'd9, 1'b0, "R12 pd rem");
    // R3 hold without ticks
    repeat (5) @(negedge clk);
    rd(6'd36, 3'd4, 32'd7, 1'b0, "R3 hold");
    // R3 advance for exactly three ticks
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b0;
    rd(6'd36, 3'd4, 32'd4, 1'b0, "R3 advance os");
    rd(6'd44, 3'd4, 32'd6, 1'b0, "R12 advance pd");
    wr(6'd40, 32'd0, 3'd4, 1'b0, "R6 stop pd");
    wr(6'd32, 32'd0, 3'd4, 1'b0, "R6 stop os");

    // R4 exact expiry timing
    tick_en = 1'b1;
    wr(6'd32, 32'd5, 3'd4, 1'b0, "R4 arm");
    os_cnt = 0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk(os_fire == (k == 5), "R4 pulse timing", {31'h0, os_fire}, {31'h0, k == 5});
    end
    repeat (15) @(negedge clk);
    #1;
    chk(os_cnt == 1, "R4 single pulse", os_cnt, 1);
    rd(6'd32, 3'd4, 32'd0, 1'b0, "R4 ctrl cleared");
    rd(6'd36, 3'd4, 32'd0, 1'b0, "R4 rem cleared");

    // R5 periodic
    wr(6'd40, 32'd4, 3'd4, 1'b0, "R5 arm");
    pd_cnt = 0;
    repeat (40) @(negedge clk);
    #1;
    chk(pd_cnt == 10, "R5 pulse count", pd_cnt, 10);
    tick_en = 1'b0;
    rd(6'd40, 3'd4, 32'd4, 1'b0, "R5 ctrl kept");
    rd(6'd44, 3'd4, 32'd4, 1'b0, "R5 reloaded");

    // R6 stop
    wr(6'd40, 32'd0, 3'd4, 1'b0, "R6 write zero");
    tick_en = 1'b1;
    pd_cnt = 0;
    repeat (20) @(negedge clk);
    #1;
    chk(pd_cnt == 0, "R6 no pulses", pd_cnt, 0);
    rd(6'd40, 3'd4, 32'd0, 1'b0, "R6 ctrl");
    rd(6'd44, 3'd4, 32'd0, 1'b0, "R6 rem");

    // R7 restart on rewrite
    wr(6'd32, 32'd6, 3'd4, 1'b0, "R7 arm");
    repeat (3) @(negedge clk);
    wr(6'd32, 32'd6, 3'd4, 1'b0, "R7 rearm");
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk(os_fire == (k == 6), "R7 restart timing", {31'h0, os_fire}, {31'h0, k == 6});
    end

    // R8 write coinciding with expiry
    wr(6'd32, 32'd3, 3'd4, 1'b0, "R8 arm");
    repeat (2) @(negedge clk);
    wr(6'd32, 32'd8, 3'd4, 1'b0, "R8 colliding write");
    chk(os_fire == 1'b0, "R8 suppressed pulse", {31'h0, os_fire}, 32'h0);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk(os_fire == (k == 8), "R8 new count", {31'h0, os_fire}, {31'h0, k == 8});
    end

    // R9 size errors
    tick_en = 1'b0;
    wr(6'd32, 32'd50, 3'd2, 1'b1, "R9 bad write");
    rd(6'd32, 3'd4, 32'd0, 1'b0, "R9 ctrl unchanged");
    wr(6'd32, 32'd12, 3'd4, 1'b0, "R9 good write");
    rd(6'd32, 3'd1, 32'd0, 1'b1, "R9 bad read");
    rd(6'd36, 3'd3, 32'd0, 1'b1, "R9 bad read rem");
    rd(6'd36, 3'd4, 32'd12, 1'b0, "R9 rem intact");

    // R10 read-only and unmapped
    wr(6'd36, 32'd77, 3'd4, 1'b0, "R10 write os rem");
    wr(6'd44, 32'd99, 3'd4, 1'b0, "R10 write pd rem");
    wr(6'd0, 32'd5, 3'd4, 1'b0, "R10 write unmapped");
    rd(6'd36, 3'd4, 32'd12, 1'b0, "R10 os rem ignored");
    rd(6'd44, 3'd4, 32'd0, 1'b0, "R10 pd rem ignored");
    rd(6'd40, 3'd4, 32'd0, 1'b0, "R10 pd ctrl untouched");
    rd(6'd0, 3'd4, 32'd0, 1'b0, "R10 unmapped read");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
    summary();
  end
endmodule